// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit down-counter. Software programs a reload value and a control word. It then writes a fixed key word to a restart register, which copies the reload value into the counter. From then on the counter must be restarted with the key before it runs out.

The counter decrements once per count step. Depending on a control bit, a step is either every system clock or only the clock cycles in which the 1 MHz tick-enable input is high. When a step finds the counter at zero, the block does three things:

- It latches a timeout status flag.
- It reloads the counter.
- If the reset action is enabled, it clears its own run bit and drives a reset pulse. The pulse lasts a programmable number of system-clock cycles. It is accompanied by the reset mode latched at the moment of firing and a 64-bit per-controller target mask.

The register port is a plain single-cycle 32-bit write strobe with an asynchronous read mux. It carries no data stream, so it has no valid/ready handshake and no back-pressure: every write is taken on the clock edge at which the strobe is high.

Register byte offsets are as follows. Only these word-aligned addresses decode; any other address reads zero and ignores writes.

| Offset | Register |
|--------|----------|
| 0x00 | current count, read-only |
| 0x04 | reload value |
| 0x08 | restart |
| 0x0C | control |
| 0x10 | timeout status |
| 0x14 | status clear |
| 0x18 | pulse width |
| 0x1C | mask bits 31:0 |
| 0x20 | mask bits 63:32 |

The control word holds these fields:

| Bit(s) | Field |
|--------|-------|
| 0 | run |
| 1 | reset enable |
| 4 | tick select |
| 6:5 | reset mode (0 SoC, 1 whole chip, 2 CPU only) |
| 7 | second-boot flag, stored only |

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, the control register reads 0, the reload value reads 0xFFFFFFFF, the count reads 0xFFFFFFFF, both mask registers read 0, and `wdt_rst` and `wdt_timeout` are low.
- R2: A write of exactly 0x00004755 (all 32 bits compared) to offset 0x08 loads the count from the reload value on that clock edge, whether or not the counter is running. Any other value written there leaves the count unchanged.
- R3: While run (bit 0) is set, the count decrements by one per step. A step is every clock when bit 4 is 0, and only clocks with `tick_1us` high when bit 4 is 1. Expiry is the step that finds the count at 0, so a reload of N expires on the (N+1)-th step, and a reload of 0 expires on the first step.
- R4: Expiry sets `wdt_timeout` (status bit 0 at 0x10) on the expiry edge. It stays set until a write to 0x14 with bit 0 = 1; a write to 0x14 with bit 0 = 0 has no effect.
- R5: With run clear, the count holds its value and no expiry occurs.
- R6: On expiry with reset enable (bit 1) set, `wdt_rst` rises on the expiry edge and stays high for max(W,1) clock cycles, where W is the value at 0x18. With bit 1 clear, `wdt_rst` stays low.
- R7: Expiry reloads the count from the reload value. With reset enable set, expiry also clears run while leaving the other control bits intact; without it, counting continues.
- R8: `wdt_rst_mode` presents control bits 6:5 as captured at the expiry that fired the reset, and holds that value afterwards.
- R9: `wdt_rst_mask` equals {register 0x20, register 0x1C}, and both registers read back as written.
- R10: The control register stores only bits 0, 1, 4, 5, 6 and 7 and reads the other bits as 0. Offsets 0x08 and 0x14 read 0. Writes to the count register at 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle-wide 1 MHz count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst | output | 1 | Reset pulse to the controllers |
| wdt_rst_mode | output | 2 | Reset mode captured at firing |
| wdt_rst_mask | output | 64 | Per-controller reset target mask |
| wdt_timeout | output | 1 | Latched timeout status |

## Verification
The timing is the same for every register:

- A register write takes effect on the clock edge that samples the strobe, so readback is valid at the next falling edge.
- A keyed restart loads the count on that same edge.
- After the run bit is written, expiry lands on the (N+1)-th following count step. `wdt_timeout` and `wdt_rst` both rise on that edge and are visible one nanosecond after it.
- The pulse then stays high for exactly max(W,1) further edges.

The bench counts edges from the write that started the counter, samples every output 1 ns after an edge or at a falling edge, and compares the edge count against the value each requirement gives, rather than waiting for an output to change.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

  // word indices; byte offset = 4 * index
  localparam int RG_COUNT   = 0;
  localparam int RG_RELOAD  = 1;
  localparam int RG_RESTART = 2;
  localparam int RG_CTRL    = 3;
  localparam int RG_STATUS  = 4;
  localparam int RG_CLEAR   = 5;
  localparam int RG_WIDTH   = 6;
  localparam int RG_MASKLO  = 7;
  localparam int RG_MASKHI  = 8;

  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_RSTEN = 1;
  localparam int CB_TSEL  = 4;
  localparam int CB_MODE  = 5;
  localparam int CB_BOOT2 = 7;

  typedef struct packed {
    logic       boot2;
    logic [1:0] mode;
    logic       tick_sel;
    logic       rst_en;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  input  logic          fire_rst,
  input  logic [DW-1:0] cnt,
  output logic [DW-1:0] rdata,
  output ctrl_t         ctrl,
  output logic [DW-1:0] reload,
  output logic [DW-1:0] width,
  output logic [2*DW-1:0] mask,
  output logic          restart_hit,
  output logic          timeout
);
  logic [DW-1:0] mask_lo, mask_hi;
  logic hit_reload, hit_restart, hit_ctrl, hit_clear, hit_width, hit_lo, hit_hi;

  assign hit_reload  = wr && (addr == AW'(RG_RELOAD * 4));
  assign hit_restart = wr && (addr == AW'(RG_RESTART * 4));
  assign hit_ctrl    = wr && (addr == AW'(RG_CTRL * 4));
  assign hit_clear   = wr && (addr == AW'(RG_CLEAR * 4));
  assign hit_width   = wr && (addr == AW'(RG_WIDTH * 4));
  assign hit_lo      = wr && (addr == AW'(RG_MASKLO * 4));
  assign hit_hi      = wr && (addr == AW'(RG_MASKHI * 4));

  assign restart_hit = hit_restart && (wdata == DW'(RESTART_KEY));
  assign mask        = {mask_hi, mask_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      reload  <= '1;
      width   <= '0;
      mask_lo <= '0;
      mask_hi <= '0;
      timeout <= 1'b0;
    end else begin
      if (hit_reload) reload  <= wdata;
      if (hit_width)  width   <= wdata;
      if (hit_lo)     mask_lo <= wdata;
      if (hit_hi)     mask_hi <= wdata;
      if (hit_ctrl) begin
        ctrl.run      <= wdata[CB_RUN];
        ctrl.rst_en   <= wdata[CB_RSTEN];
        ctrl.tick_sel <= wdata[CB_TSEL];
        ctrl.mode     <= wdata[CB_MODE +: 2];
        ctrl.boot2    <= wdata[CB_BOOT2];
      end
      if (fire_rst) ctrl.run <= 1'b0;
      if (expire) timeout <= 1'b1;
      else if (hit_clear && wdata[0]) timeout <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(RG_COUNT * 4):  rdata = cnt;
      AW'(RG_RELOAD * 4): rdata = reload;
      AW'(RG_CTRL * 4): begin
        rdata[CB_RUN]        = ctrl.run;
        rdata[CB_RSTEN]      = ctrl.rst_en;
        rdata[CB_TSEL]       = ctrl.tick_sel;
        rdata[CB_MODE +: 2]  = ctrl.mode;
        rdata[CB_BOOT2]      = ctrl.boot2;
      end
      AW'(RG_STATUS * 4): rdata[0] = timeout;
      AW'(RG_WIDTH * 4):  rdata = width;
      AW'(RG_MASKLO * 4): rdata = mask_lo;
      AW'(RG_MASKHI * 4): rdata = mask_hi;
      default:            rdata = '0;
    endcase
  end

  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rst |=> !ctrl.run);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !(hit_clear && wdata[0]) |=> timeout);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_sel,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  logic step;

  assign step   = run && (tick_sel ? tick : 1'b1);
  assign expire = step && !restart && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '1;
    else if (restart)    cnt <= reload;
    else if (step)       cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  a_r2_key_load: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == $past(reload));
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    step && !restart && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !restart |=> $stable(cnt));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [WW-1:0] width,
  input  logic [1:0]    mode_in,
  output logic          rst_out,
  output logic [1:0]    mode_out
);
  logic [WW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left     <= '0;
      mode_out <= '0;
    end else if (fire) begin
      left     <= (width == '0) ? WW'(1) : width;
      mode_out <= mode_in;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign rst_out = (left != '0);

  a_r6_fire_high: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rst_out);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out && !fire |=> !rst_out);
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(mode_out));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_1us,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            wdt_rst,
  output logic [1:0]      wdt_rst_mode,
  output logic [2*DW-1:0] wdt_rst_mask,
  output logic            wdt_timeout
);
  localparam int MW = 2 * DW;

  ctrl_t         ctrl;
  logic [DW-1:0] reload, width, cnt;
  logic [MW-1:0] mask;
  logic          restart_hit, expire, fire_rst;

  assign fire_rst     = expire && ctrl.rst_en;
  assign wdt_rst_mask = mask;

  wdt_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .expire(expire), .fire_rst(fire_rst), .cnt(cnt), .rdata(bus_rdata),
    .ctrl(ctrl), .reload(reload), .width(width), .mask(mask),
    .restart_hit(restart_hit), .timeout(wdt_timeout)
  );

  wdt_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick_sel(ctrl.tick_sel),
    .tick(tick_1us), .restart(restart_hit), .reload(reload),
    .cnt(cnt), .expire(expire)
  );

  wdt_pulse #(.WW(DW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire_rst), .width(width),
    .mode_in(ctrl.mode), .rst_out(wdt_rst), .mode_out(wdt_rst_mode)
  );

  a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wdt_timeout);
endmodule

// File: tb/sim_wdt_keyed_top.sv
`timescale 1ns/1ps
module sim_wdt_keyed_top;
  localparam logic [5:0] A_CNT = 6'h00, A_REL = 6'h04, A_RST = 6'h08, A_CTL = 6'h0C,
                         A_STS = 6'h10, A_CLR = 6'h14, A_WID = 6'h18, A_MLO = 6'h1C,
                         A_MHI = 6'h20;
  localparam logic [31:0] KEY = 32'h0000_4755;
  localparam int NV = 5;
  localparam logic [31:0] V_RELOAD [NV] = '{32'd0, 32'd1, 32'd2, 32'd5, 32'd17};
  localparam int          V_EDGES  [NV] = '{1, 2, 3, 6, 18};

  logic clk = 0, rst_n = 0, tick_1us = 0, bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdt_rst, wdt_timeout;
  logic [1:0] wdt_rst_mode;
  logic [63:0] wdt_rst_mask;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_keyed_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst), .wdt_rst_mode(wdt_rst_mode), .wdt_rst_mask(wdt_rst_mask),
    .wdt_timeout(wdt_timeout)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick_once();
    @(negedge clk); tick_1us = 1'b1;
    @(negedge clk); tick_1us = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, a_cnt;
    int k;
    bit got;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_CTL, d); chk("R1 ctrl", d, 0);
    rd(A_REL, d); chk("R1 reload", d, 32'hFFFF_FFFF);
    rd(A_CNT, d); chk("R1 count", d, 32'hFFFF_FFFF);
    rd(A_MLO, d); chk("R1 mask lo", d, 0);
    rd(A_MHI, d); chk("R1 mask hi", d, 0);
    chk("R1 rst", wdt_rst, 0);
    chk("R1 timeout", wdt_timeout, 0);

    // R3/R7 vector table: reload N expires after N+1 clock steps, then auto-reloads
    for (int i = 0; i < NV; i++) begin
      wr(A_CTL, 0); wr(A_CLR, 1);
      wr(A_REL, V_RELOAD[i]); wr(A_RST, KEY);
      wr(A_CTL, 32'h1);
      k = 0; got = 0;
      for (int s = 1; s <= 64 && !got; s++) begin
        @(posedge clk); #1;
        if (wdt_timeout) begin k = s; got = 1; end
      end
      chk("R3 expiry edge", k, V_EDGES[i]);
      chk("R6 no pulse without enable", wdt_rst, 0);
      rd(A_CNT, d); chk("R7 auto reload", d, V_RELOAD[i]);
      rd(A_CTL, d); chk("R7 run kept", d, 32'h1);
    end

    // R4 status clear semantics
    wr(A_CTL, 0);
    wr(A_CLR, 32'hFFFF_FFFE); chk("R4 clear bit0=0 ignored", wdt_timeout, 1);
    wr(A_CLR, 1);             chk("R4 clear", wdt_timeout, 0);

    // R6/R7/R8 reset pulse, width 3, mode 2
    wr(A_WID, 3); wr(A_REL, 2); wr(A_RST, KEY);
    wr(A_CTL, 32'h43);
    repeat (2) begin @(posedge clk); #1; chk("R6 low before expiry", wdt_rst, 0); end
    @(posedge clk); #1;
    chk("R6 rise", wdt_rst, 1); chk("R8 mode 2", wdt_rst_mode, 2); chk("R4 set", wdt_timeout, 1);
    repeat (2) begin @(posedge clk); #1; chk("R6 held", wdt_rst, 1); end
    @(posedge clk); #1; chk("R6 fall after 3", wdt_rst, 0);
    chk("R8 mode held", wdt_rst_mode, 2);
    rd(A_CTL, d); chk("R7 run self-cleared", d, 32'h42);
    rd(A_CNT, d); chk("R7 reloaded and frozen", d, 2);

    // R6 width 0 -> one cycle, mode 1
    wr(A_CLR, 1); wr(A_WID, 0); wr(A_RST, KEY);
    wr(A_CTL, 32'h23);
    repeat (2) @(posedge clk);
    @(posedge clk); #1;
    chk("R6 min width rise", wdt_rst, 1); chk("R8 mode 1", wdt_rst_mode, 1);
    @(posedge clk); #1; chk("R6 min width fall", wdt_rst, 0);

    // R3 tick mode
    wr(A_CTL, 0); wr(A_CLR, 1); wr(A_REL, 1); wr(A_RST, KEY);
    wr(A_CTL, 32'h11);
    repeat (20) @(posedge clk);
    rd(A_CNT, d); chk("R3 no tick no step", d, 1);
    tick_once();
    rd(A_CNT, d); chk("R3 tick step", d, 0);
    chk("R3 not yet expired", wdt_timeout, 0);
    tick_once();
    chk("R3 tick expiry", wdt_timeout, 1);
    rd(A_CNT, d); chk("R7 tick reload", d, 1);

    // R5 disable freezes
    wr(A_CTL, 0); wr(A_CLR, 1); wr(A_REL, 40); wr(A_RST, KEY);
    wr(A_CTL, 1);
    repeat (5) @(posedge clk);
    wr(A_CTL, 0);
    rd(A_CNT, a_cnt); chk("R5 count at stop", a_cnt, 34);
    repeat (10) @(posedge clk);
    rd(A_CNT, d); chk("R5 frozen", d, 34);
    chk("R5 no expiry", wdt_timeout, 0);

    // R2 key check and R10 count write ignored
    wr(A_REL, 100); wr(A_RST, KEY);
    rd(A_CNT, d); chk("R2 keyed load", d, 100);
    wr(A_REL, 50);
    wr(A_RST, 32'h0000_4756);  rd(A_CNT, d); chk("R2 wrong key ignored", d, 100);
    wr(A_RST, 32'h0001_4755);  rd(A_CNT, d); chk("R2 upper bits compared", d, 100);
    wr(A_CNT, 32'h55);         rd(A_CNT, d); chk("R10 count read-only", d, 100);
    wr(A_RST, KEY);            rd(A_CNT, d); chk("R2 keyed reload", d, 50);

    // R9 mask
    wr(A_MLO, 32'hA5A5_0001); wr(A_MHI, 32'h8000_00FF);
    chk("R9 mask out", wdt_rst_mask, 64'h8000_00FF_A5A5_0001);
    rd(A_MLO, d); chk("R9 lo readback", d, 32'hA5A5_0001);
    rd(A_MHI, d); chk("R9 hi readback", d, 32'h8000_00FF);

    // R10 control storage and write-only offsets
    wr(A_CTL, 32'hFFFF_FF0C); rd(A_CTL, d); chk("R10 reserved bits", d, 0);
    wr(A_CTL, 32'h80);        rd(A_CTL, d); chk("R10 boot flag", d, 32'h80);
    rd(A_RST, d); chk("R10 restart reads 0", d, 0);
    rd(A_CLR, d); chk("R10 clear reads 0", d, 0);

    finish_run();
  end
endmodule